// File: doc/BRIEF.md
# Packed Saturating Doubling Multiply-High Unit

This block is a vector arithmetic datapath. It treats two operand vectors as packed signed lanes of 16 or 32 bits. For each active lane it forms twice the signed product of the two lanes and may add a half-LSB rounding term. It then keeps the upper half of that sum, arithmetically shifted down by the lane width, and clamps it to the signed range of one lane. The upper half of the operand vector can be switched off to give a 64-bit operation, or a scalar mode can process only the lowest lane.

A strobe launches one operation. The packed result appears in a register one cycle later, together with a valid pulse. A sticky saturation flag records that at least one active lane was clamped since the flag was last cleared. The flag is cleared only by a synchronous clear input or by reset. A lane-size code that is not supported produces a zero result and a one-cycle illegal-operation pulse, and it leaves the flag untouched.

Top module: `simd_dmulh`

## Requirements
- R1: `lane_code` 2'b01 selects 16-bit lanes and 2'b10 selects 32-bit lanes. Lane 0 occupies the least significant bits and lanes count upward in bit order.
- R2: Each active lane result equals the saturated value of (2·a·b + k) shifted arithmetically right by the lane width. It is computed at full precision, with a and b the signed lane values.
- R3: The rounding term k is 2^(lane width − 1) when `round_sel` is 1, and 0 otherwise.
- R4: In vector mode the active width is 128 bits when `wide_sel` is 1 and 64 bits otherwise. Result bits above the active width are zero.
- R5: With `scalar_sel` at 1, only lane 0 is computed and `wide_sel` is ignored. Every result bit above the lane width is zero.
- R6: A lane saturates only when both of its operands hold the most negative lane value. The result is then the most positive lane value, with or without rounding.
- R7: `sat_flag` becomes 1 after any operation in which an active lane saturates, and it stays 1 through later operations. Saturation in an inactive lane does not set it.
- R8: `sat_clear` clears `sat_flag` at the next clock edge. If a saturating operation is issued in the same cycle, the flag ends up set.
- R9: Codes 2'b00 and 2'b11 give a zero result, leave `sat_flag` unchanged, and raise `illegal_op` for exactly the cycle in which `out_valid` is high.
- R10: `out_valid` is high exactly one cycle after each cycle with `in_valid` high. `result` is loaded only then and holds its value otherwise.
- R11: While `rst_n` is low at a clock edge, `out_valid`, `illegal_op`, `sat_flag` and `result` all become zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Launch an operation this cycle |
| op_a | input | 128 | First packed operand |
| op_b | input | 128 | Second packed operand |
| lane_code | input | 2 | Lane size code (01: 16-bit, 10: 32-bit, others illegal) |
| wide_sel | input | 1 | 1: 128-bit vector, 0: 64-bit vector |
| scalar_sel | input | 1 | 1: process lane 0 only |
| round_sel | input | 1 | 1: add half-LSB rounding term |
| sat_clear | input | 1 | Synchronous clear of the sticky flag |
| out_valid | output | 1 | Result register updated in the previous cycle |
| result | output | 128 | Packed saturated result |
| sat_flag | output | 1 | Sticky cumulative saturation flag |
| illegal_op | output | 1 | Pulse for an operation with a reserved lane code |

## Verification
The hardest case to reach is a most-negative operand pair placed in a lane that the current mode switches off. That lane then computes a clamp internally, and the sticky flag must not record it. A random draw seldom produces this. The stimulus therefore deliberately fills the upper 64 bits, and every lane above lane 0, with most-negative pairs, while the mode is 64-bit or scalar. A second directed case issues a clear and a saturating operation in the same cycle. Beyond these, random operations bias each 32-bit word toward most-negative patterns, so that clamps, reserved codes and clears interleave, and a behavioural model checks every clock.

// File: rtl/simd_dmulh_pkg.sv
// Package: shared constants and the lane-size code type for the
// saturating doubling multiply-high unit.
package simd_dmulh_pkg;

    // Lane-size code values; the two legal codes pick 16 and 32-bit lanes.
    typedef enum logic [1:0] {
        LCODE_RSV0 = 2'b00,
        LCODE_H16  = 2'b01,
        LCODE_W32  = 2'b10,
        LCODE_RSV3 = 2'b11
    } lane_code_e;

    localparam int unsigned NARROW_LANE_W = 16;
    localparam int unsigned WIDE_LANE_W   = 32;

endpackage

// File: rtl/dmulh_lane.sv
// Module: dmulh_lane
// Computes one lane: sat((2*a*b + k) >>> LW), with k the optional
// half-LSB rounding term. Purely combinational.
// Assumes: operands are two's complement LW-bit values; the internal
// width 2*LW+2 holds the doubled product plus rounding without overflow.
module dmulh_lane #(
    parameter int unsigned LW = 16
) (
    input  logic [LW-1:0] a_i,
    input  logic [LW-1:0] b_i,
    input  logic          rnd_i,
    output logic [LW-1:0] res_o,
    output logic          sat_o
);
    localparam int unsigned PW = 2 * LW + 2;
    localparam logic signed [PW-1:0] MAXV = {{(PW-LW+1){1'b0}}, {(LW-1){1'b1}}};
    localparam logic signed [PW-1:0] MINV = {{(PW-LW+1){1'b1}}, {(LW-1){1'b0}}};
    localparam logic [LW-1:0] LANE_MIN = {1'b1, {(LW-1){1'b0}}};

    logic signed [PW-1:0] ext_a;
    logic signed [PW-1:0] ext_b;
    logic signed [PW-1:0] round_k;
    logic signed [PW-1:0] full_sum;
    logic signed [PW-1:0] high_part;
    logic                 over_hi;
    logic                 over_lo;

    // Sign-extend operands and form the rounding term.
    always_comb begin
        ext_a   = {{(PW-LW){a_i[LW-1]}}, a_i};
        ext_b   = {{(PW-LW){b_i[LW-1]}}, b_i};
        round_k = rnd_i ? {{(PW-LW){1'b0}}, 1'b1, {(LW-1){1'b0}}} : '0;
    end

    // Doubled full-precision product plus rounding, then take the high part.
    always_comb begin
        full_sum  = ((ext_a * ext_b) <<< 1) + round_k;
        high_part = full_sum >>> LW;
    end

    // Clamp the high part into the signed lane range.
    always_comb begin
        over_hi = (high_part > MAXV);
        over_lo = (high_part < MINV);
        sat_o   = over_hi | over_lo;
        if (over_hi)      res_o = MAXV[LW-1:0];
        else if (over_lo) res_o = MINV[LW-1:0];
        else              res_o = high_part[LW-1:0];
    end

    // Only a most-negative pair may clamp.
    always_comb begin
        AST_SAT_ONLY_MIN: assert (!sat_o || (a_i == LANE_MIN && b_i == LANE_MIN)); // R6
    end

endmodule

// File: rtl/dmulh_lane_bank.sv
// Module: dmulh_lane_bank
// Replicates dmulh_lane across a DW-bit vector at one lane width and
// masks lanes that the mode switches off (upper half in 64-bit mode,
// all but lane 0 in scalar mode). Masked lanes give zero and no saturation.
// Assumes: DW is a multiple of 2*LW.
module dmulh_lane_bank #(
    parameter int unsigned DW = 128,
    parameter int unsigned LW = 16
) (
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic          rnd_i,
    input  logic          wide_i,
    input  logic          scalar_i,
    output logic [DW-1:0] res_o,
    output logic          sat_any_o
);
    localparam int unsigned NL   = DW / LW;
    localparam int unsigned HALF = NL / 2;

    logic [NL-1:0] lane_act;
    logic [NL-1:0] lane_sat;

    for (genvar i = 0; i < NL; i++) begin : g_lane
        logic [LW-1:0] lres;
        logic          lsat;

        dmulh_lane #(.LW(LW)) u_lane (
            .a_i   (a_i[i*LW +: LW]),
            .b_i   (b_i[i*LW +: LW]),
            .rnd_i (rnd_i),
            .res_o (lres),
            .sat_o (lsat)
        );

        // Decide whether this lane takes part in the current mode.
        always_comb begin
            if (scalar_i) lane_act[i] = (i == 0);
            else          lane_act[i] = wide_i || (i < HALF);
        end

        // Gate the lane result and its saturation by the activity mask.
        always_comb begin
            res_o[i*LW +: LW] = lane_act[i] ? lres : '0;
            lane_sat[i]       = lane_act[i] & lsat;
        end
    end

    // Combine per-lane saturation into one indication.
    always_comb sat_any_o = |lane_sat;

endmodule

// File: rtl/simd_dmulh.sv
// Module: simd_dmulh (top)
// Saturating doubling multiply-high on packed 16 or 32-bit signed lanes.
// Two lane banks run in parallel; the lane code picks one. The result is
// registered one cycle after in_valid; a sticky flag collects saturation.
// Assumes: synchronous active-low reset; inputs are stable around clk.
module simd_dmulh
    import simd_dmulh_pkg::*;
#(
    parameter int unsigned DATA_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [1:0]        lane_code,
    input  logic              wide_sel,
    input  logic              scalar_sel,
    input  logic              round_sel,
    input  logic              sat_clear,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              sat_flag,
    output logic              illegal_op
);
    localparam int unsigned HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] res_n;
    logic [DATA_W-1:0] res_w;
    logic              sat_n;
    logic              sat_w;
    logic              code_ok;
    logic [DATA_W-1:0] res_sel;
    logic              sat_sel;
    lane_code_e        code;

    dmulh_lane_bank #(.DW(DATA_W), .LW(NARROW_LANE_W)) u_bank16 (
        .a_i       (op_a),
        .b_i       (op_b),
        .rnd_i     (round_sel),
        .wide_i    (wide_sel),
        .scalar_i  (scalar_sel),
        .res_o     (res_n),
        .sat_any_o (sat_n)
    );

    dmulh_lane_bank #(.DW(DATA_W), .LW(WIDE_LANE_W)) u_bank32 (
        .a_i       (op_a),
        .b_i       (op_b),
        .rnd_i     (round_sel),
        .wide_i    (wide_sel),
        .scalar_i  (scalar_sel),
        .res_o     (res_w),
        .sat_any_o (sat_w)
    );

    // Decode the lane code and select the matching bank output.
    always_comb begin
        code    = lane_code_e'(lane_code);
        code_ok = 1'b0;
        res_sel = '0;
        sat_sel = 1'b0;
        case (code)
            LCODE_H16: begin code_ok = 1'b1; res_sel = res_n; sat_sel = sat_n; end
            LCODE_W32: begin code_ok = 1'b1; res_sel = res_w; sat_sel = sat_w; end
            default:   begin code_ok = 1'b0; res_sel = '0;    sat_sel = 1'b0;  end
        endcase
    end

    // Output register, valid/illegal pulses and the sticky saturation flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            illegal_op <= 1'b0;
            sat_flag   <= 1'b0;
            result     <= '0;
        end else begin
            out_valid  <= in_valid;
            illegal_op <= in_valid && !code_ok;
            sat_flag   <= (sat_flag && !sat_clear) || (in_valid && sat_sel);
            if (in_valid) result <= res_sel;
        end
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R10
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R10
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result)); // R10
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_flag && !sat_clear) |=> sat_flag); // R7
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_clear && !(in_valid && sat_sel)) |=> !sat_flag); // R8
    AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !code_ok) |=> (illegal_op && result == '0)); // R9
    AST_ILLEGAL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !code_ok && !sat_clear) |=> $stable(sat_flag)); // R9
    AST_ILLEGAL_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_op |-> out_valid); // R9
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (scalar_sel || !wide_sel)) |=> result[DATA_W-1:HALF_W] == '0); // R4

endmodule

// File: tb/sim_simd_dmulh.sv
// Bench: behavioural reference model compared against the unit every clock.
module sim_simd_dmulh;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [127:0] op_a = '0;
    logic [127:0] op_b = '0;
    logic [1:0]   lane_code = 2'b01;
    logic         wide_sel = 1'b0;
    logic         scalar_sel = 1'b0;
    logic         round_sel = 1'b0;
    logic         sat_clear = 1'b0;
    logic         out_valid;
    logic [127:0] result;
    logic         sat_flag;
    logic         illegal_op;

    int    checks = 0;
    int    errors = 0;
    bit    started = 0;
    bit    done = 0;
    string cur_req = "R11";

    logic [127:0] m_res = '0;
    logic         m_valid = 0, m_flag = 0, m_ill = 0;

    always #10 clk = ~clk;

    simd_dmulh u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .lane_code(lane_code), .wide_sel(wide_sel), .scalar_sel(scalar_sel),
        .round_sel(round_sel), .sat_clear(sat_clear), .out_valid(out_valid),
        .result(result), .sat_flag(sat_flag), .illegal_op(illegal_op)
    );

    // Reference: per lane, full precision, from the requirements.
    function automatic void ref_op(input logic [127:0] a, input logic [127:0] b,
                                   input logic [1:0] code, input logic wide,
                                   input logic scal, input logic rnd,
                                   output logic [127:0] r, output logic s);
        int lw, n;
        r = '0; s = 0;
        if (code != 2'b01 && code != 2'b10) return;
        lw = (code == 2'b01) ? 16 : 32;
        n  = scal ? 1 : ((wide ? 128 : 64) / lw);
        for (int i = 0; i < n; i++) begin
            logic [127:0] ra, rb;
            logic signed [67:0] x, y, p, mx, mn;
            ra = a >> (i * lw);
            rb = b >> (i * lw);
            if (lw == 16) begin
                x = {{52{ra[15]}}, ra[15:0]};
                y = {{52{rb[15]}}, rb[15:0]};
            end else begin
                x = {{36{ra[31]}}, ra[31:0]};
                y = {{36{rb[31]}}, rb[31:0]};
            end
            p  = 68'sd2 * x * y + (rnd ? (68'sd1 <<< (lw - 1)) : 68'sd0);
            p  = p >>> lw;
            mx = (68'sd1 <<< (lw - 1)) - 68'sd1;
            mn = -(68'sd1 <<< (lw - 1));
            if (p > mx) begin p = mx; s = 1; end
            else if (p < mn) begin p = mn; s = 1; end
            r = r | ((128'(p) & ((128'd1 << lw) - 128'd1)) << (i * lw));
        end
    endfunction

    // Model state advances on the same edge as the unit.
    always @(posedge clk) begin
        logic [127:0] r;
        logic s;
        started = 1;
        if (!rst_n) begin
            m_res = '0; m_valid = 0; m_flag = 0; m_ill = 0;
        end else begin
            ref_op(op_a, op_b, lane_code, wide_sel, scalar_sel, round_sel, r, s);
            if (!in_valid) s = 0;
            m_valid = in_valid;
            m_ill   = in_valid && (lane_code == 2'b00 || lane_code == 2'b11);
            if (in_valid) m_res = r;
            m_flag  = (m_flag && !sat_clear) || s;
        end
    end

    task automatic chk(input string what, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    // Compare every clock, away from the active edge.
    always @(negedge clk) begin
        if (started && !done) begin
            chk("out_valid", 128'(out_valid), 128'(m_valid));
            chk("illegal_op", 128'(illegal_op), 128'(m_ill));
            chk("sat_flag", 128'(sat_flag), 128'(m_flag));
            chk("result", result, m_res);
        end
    end

    task automatic issue(input logic [127:0] a, input logic [127:0] b, input logic [1:0] code,
                         input logic wide, input logic scal, input logic rnd, input logic clr);
        op_a = a; op_b = b; lane_code = code; wide_sel = wide;
        scalar_sel = scal; round_sel = rnd; sat_clear = clr; in_valid = 1;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        in_valid = 0; sat_clear = 0;
        repeat (n) @(negedge clk);
    endtask

    task automatic do_clear();
        in_valid = 0; sat_clear = 1;
        @(negedge clk);
        sat_clear = 0;
    endtask

    localparam logic [127:0] MIN16 = {8{16'h8000}};
    localparam logic [127:0] MIN32 = {4{32'h8000_0000}};

    initial begin
        repeat (3) @(negedge clk);             // R11 reset state checked each cycle
        rst_n = 1;
        idle(1);
        cur_req = "R1";
        issue(128'h0004_0003_0002_0001_FFFF_0100_4000_0002,
              128'h0100_0200_0300_0400_0001_0100_7FFF_3000, 2'b01, 1, 0, 0, 0);
        issue(128'h7FFF_FFFF_8000_0001_1234_5678_9ABC_DEF0,
              128'h0000_0002_7FFF_FFFF_0FED_CBA9_8765_4321, 2'b10, 1, 0, 0, 0);
        cur_req = "R2";
        issue({8{16'hC000}}, {8{16'h4000}}, 2'b01, 1, 0, 0, 0);
        issue({4{32'h7FFF_FFFF}}, {4{32'h7FFF_FFFF}}, 2'b10, 1, 0, 0, 0);
        cur_req = "R3";
        issue({8{16'h4000}}, {8{16'h0001}}, 2'b01, 1, 0, 1, 0);
        issue({8{16'h4000}}, {8{16'h0001}}, 2'b01, 1, 0, 0, 0);
        issue({4{32'hC000_0000}}, {4{32'h0000_0001}}, 2'b10, 1, 0, 1, 0);
        cur_req = "R4";
        issue({8{16'h2345}}, {8{16'h3456}}, 2'b01, 0, 0, 0, 0);
        issue({4{32'h2345_6789}}, {4{32'h3456_789A}}, 2'b10, 0, 0, 1, 0);
        cur_req = "R5";
        issue({8{16'h2345}}, {8{16'h3456}}, 2'b01, 1, 1, 0, 0);
        issue({4{32'h2345_6789}}, {4{32'h3456_789A}}, 2'b10, 1, 1, 1, 0);
        cur_req = "R7";                         // inactive min pairs must not set flag
        issue({MIN16[127:64], 64'h1}, {MIN16[127:64], 64'h1}, 2'b01, 0, 0, 0, 0);
        issue({MIN32[127:32], 32'h5}, {MIN32[127:32], 32'h5}, 2'b10, 1, 1, 1, 0);
        idle(2);
        cur_req = "R6";
        issue(MIN16, MIN16, 2'b01, 1, 0, 0, 0);
        issue(MIN32, MIN32, 2'b10, 1, 0, 1, 0);
        cur_req = "R7";
        issue({8{16'h0101}}, {8{16'h0202}}, 2'b01, 1, 0, 0, 0);
        idle(2);
        cur_req = "R8";
        do_clear();
        idle(1);
        issue(MIN32, MIN32, 2'b10, 0, 1, 0, 1);   // clear and saturate together
        idle(1);
        do_clear();
        idle(1);
        cur_req = "R9";
        issue(MIN16, MIN16, 2'b00, 1, 0, 0, 0);
        issue(MIN16, MIN16, 2'b01, 1, 0, 0, 0);
        issue(MIN32, MIN32, 2'b11, 1, 0, 1, 0);
        issue({8{16'h1111}}, {8{16'h2222}}, 2'b11, 1, 0, 0, 1);
        cur_req = "R10";
        issue({8{16'h7777}}, {8{16'h0333}}, 2'b01, 1, 0, 0, 0);
        idle(4);
        cur_req = "R2";
        for (int k = 0; k < 400; k++) begin
            logic [127:0] a, b;
            for (int w = 0; w < 4; w++) begin
                int sel;
                sel = $urandom_range(0, 3);
                a[w*32 +: 32] = (sel == 1) ? 32'h8000_8000 : (sel == 2) ? 32'h8000_0000 : $urandom;
                b[w*32 +: 32] = (sel == 1) ? 32'h8000_8000 : (sel == 2) ? 32'h8000_0000 : $urandom;
            end
            issue(a, b, 2'($urandom_range(0, 3)), 1'($urandom), 1'($urandom_range(0, 3) == 0),
                  1'($urandom), $urandom_range(0, 9) == 0);
            if ($urandom_range(0, 4) == 0) idle(1);
        end
        idle(3);
        cur_req = "R11";
        rst_n = 0;
        idle(2);
        rst_n = 1;
        idle(1);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule